// File: doc/BRIEF.md
# Deadline Timer Instruction Unit

This block holds a set of countdown deadline registers for every hardware thread of an interleaved pipeline. The registers back four timing operations that let software set a lower bound on how long a code sequence takes, and optionally learn when a deadline is missed. Each cycle the decode stage may present one operation, tagged with the issuing thread, a timer index, an operation class and a deadline value. The block answers with a per-thread stall vector and a single exception channel that names the thread and timer whose armed deadline ran out.

Every thread owns its own timers, and each one counts down once per cycle until it reaches zero. An immediate load writes the timer at once. A waiting load first holds the thread, through a small per-thread state machine, until the timer's current deadline has run out, and then writes the new value. Either kind of load can arm the timer. An armed timer that reaches zero reports one exception and then disarms. When several armed timers reach zero together, a fixed-priority arbiter picks the lowest flat index, which is thread × timers-per-thread + timer. The others stay pending and are reported in the cycles that follow.

The per-thread controller has two states. In `TC_IDLE` it accepts operations. It takes the transition *begin_wait* to `TC_WAIT` when a waiting load finds its timer nonzero. In `TC_WAIT` it ignores operations from its thread. When the held timer reads zero it takes *release* back to `TC_IDLE` and writes the held value in that same cycle.

Top module: `deadline_timer_unit`

## Requirements
- R1: Synchronous reset (rst_n low at a clock edge) clears every timer to zero, disarms every timer and puts every thread controller in `TC_IDLE`. After reset `stall_vec` is all zero and `exc_valid` is low. A deadline armed before reset never reports.
- R2: `issue_op` encodings: 2'b00 immediate load, 2'b01 waiting load, 2'b10 waiting load with arming, 2'b11 immediate load with arming. An operation counts only when `issue_valid` is high. It always targets timer `issue_timer` of thread `issue_thread`.
- R3: An immediate load (00 or 11) writes `issue_value` at the end of the issue cycle. The timer then holds that value in the next cycle and decrements by one each cycle after that. An armed load of value V issued in cycle c reports its exception in cycle c+1+V.
- R4: A timer at zero stays at zero. An armed timer reports exactly one exception when it reaches zero.
- R5: A waiting load (01 or 10) that finds its timer at value T>0 in the issue cycle holds the thread in `TC_WAIT`. `stall_vec[thread]` is high from the next cycle while the timer is nonzero, which is T−1 cycles. Only a waiting load raises a stall bit.
- R6: In the cycle the held timer reads zero, the stall bit is low and the held value is written. For a waiting load with arming of value V on a timer at T>0 issued in cycle c, the exception appears in cycle c+1+T+V.
- R7: A waiting load that finds its timer already at zero does not stall and writes at once, like an immediate load.
- R8: A load without arming (00 or 01) clears the arming of the timer it writes. An earlier armed deadline on that timer then never reports.
- R9: An exception is a one-cycle `exc_valid` pulse carrying `exc_thread` and `exc_timer`. Whenever some armed timer is at zero, `exc_valid` is high in that cycle.
- R10: When several armed timers are at zero, the lowest flat index thread×4+timer is reported first. The others are reported in later cycles, so none is lost.
- R11: An operation never reads or writes the timers of any thread other than the issuing one.
- R12: An operation issued by a thread in `TC_WAIT` is ignored. It neither writes nor arms any timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| issue_valid | input | 1 | A timing operation is presented this cycle |
| issue_thread | input | THREAD_W (2) | Issuing thread |
| issue_timer | input | TIMER_W (2) | Timer index within the thread |
| issue_op | input | 2 | Operation class (see R2) |
| issue_value | input | WIDTH (32) | Deadline value in cycles |
| stall_vec | output | NTHREADS (4) | Per-thread stall request |
| exc_valid | output | 1 | Deadline-miss exception pulse |
| exc_thread | output | THREAD_W (2) | Thread of the reported timer |
| exc_timer | output | TIMER_W (2) | Index of the reported timer |

## Verification
Internal faults show up at the ports within a bounded number of cycles. An off-by-one in the countdown or in the load timing moves the exception cycle by exactly that amount, so exception arrival is measured to the cycle against c+1+V and c+1+T+V. A controller stuck in `TC_WAIT`, or one that releases early, changes the count of stall cycles, which must equal T−1. Arming that leaks across timers or threads, or that survives a plain load or a reset, produces an extra pulse within one deadline period. A lost or duplicated pulse changes the pulse count seen in the observation window.

// File: rtl/dtu_pkg.sv
package dtu_pkg;

    typedef enum logic [1:0] {
        OP_LOAD     = 2'b00,
        OP_WAIT     = 2'b01,
        OP_WAIT_ARM = 2'b10,
        OP_LOAD_ARM = 2'b11
    } op_e;

    typedef enum logic {
        TC_IDLE = 1'b0,
        TC_WAIT = 1'b1
    } tc_state_e;

    function automatic logic op_waits(op_e op);
        return (op == OP_WAIT) || (op == OP_WAIT_ARM);
    endfunction

    function automatic logic op_arms(op_e op);
        return (op == OP_WAIT_ARM) || (op == OP_LOAD_ARM);
    endfunction

endpackage

// File: rtl/dtu_thread_ctrl.sv
module dtu_thread_ctrl #(
    parameter int NTIMERS = 4,
    parameter int WIDTH   = 32,
    parameter int TIMER_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue_hit,
    input  dtu_pkg::op_e         issue_op,
    input  logic [TIMER_W-1:0]   issue_idx,
    input  logic [WIDTH-1:0]     issue_value,
    input  logic [NTIMERS-1:0]   zero_vec,
    output logic                 wr_en,
    output logic [TIMER_W-1:0]   wr_idx,
    output logic [WIDTH-1:0]     wr_value,
    output logic                 wr_arm,
    output logic                 stall
);
    import dtu_pkg::*;

    tc_state_e            state_q, state_d;
    logic [TIMER_W-1:0]   hold_idx_q;
    logic [WIDTH-1:0]     hold_val_q;
    logic                 hold_arm_q;
    logic                 begin_wait;

    // begin_wait: waiting load meets a running timer
    assign begin_wait = (state_q == TC_IDLE) && issue_hit &&
                        op_waits(issue_op) && !zero_vec[issue_idx];

    // state register and held operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= TC_IDLE;
            hold_idx_q <= '0;
            hold_val_q <= '0;
            hold_arm_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (begin_wait) begin
                hold_idx_q <= issue_idx;
                hold_val_q <= issue_value;
                hold_arm_q <= op_arms(issue_op);
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TC_IDLE: if (begin_wait)            state_d = TC_WAIT;
            TC_WAIT: if (zero_vec[hold_idx_q])  state_d = TC_IDLE;
            default:                            state_d = TC_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wr_en    = 1'b0;
        wr_idx   = issue_idx;
        wr_value = issue_value;
        wr_arm   = 1'b0;
        stall    = 1'b0;
        unique case (state_q)
            TC_IDLE: begin
                wr_en  = issue_hit && (!op_waits(issue_op) || zero_vec[issue_idx]);
                wr_arm = op_arms(issue_op);
            end
            TC_WAIT: begin
                wr_idx   = hold_idx_q;
                wr_value = hold_val_q;
                wr_arm   = hold_arm_q;
                wr_en    = zero_vec[hold_idx_q];
                stall    = !zero_vec[hold_idx_q];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dtu_timer_bank.sv
module dtu_timer_bank #(
    parameter int NTIMERS = 4,
    parameter int WIDTH   = 32,
    parameter int TIMER_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [TIMER_W-1:0]   wr_idx,
    input  logic [WIDTH-1:0]     wr_value,
    input  logic                 wr_arm,
    input  logic [NTIMERS-1:0]   clr_arm,
    output logic [NTIMERS-1:0]   zero_vec,
    output logic [NTIMERS-1:0]   armed_vec
);

    for (genvar g = 0; g < NTIMERS; g++) begin : g_timer
        logic [WIDTH-1:0] cnt_q;
        logic             arm_q;
        logic             sel;

        assign sel = wr_en && (wr_idx == TIMER_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
                arm_q <= 1'b0;
            end else if (sel) begin
                cnt_q <= wr_value;
                arm_q <= wr_arm;
            end else begin
                if (cnt_q != '0) cnt_q <= cnt_q - WIDTH'(1);
                if (clr_arm[g])  arm_q <= 1'b0;
            end
        end

        assign zero_vec[g]  = (cnt_q == '0);
        assign armed_vec[g] = arm_q;
    end

endmodule

// File: rtl/dtu_exc_arbiter.sv
module dtu_exc_arbiter #(
    parameter int NTHREADS = 4,
    parameter int NTIMERS  = 4,
    parameter int THREAD_W = 2,
    parameter int TIMER_W  = 2
) (
    input  logic [NTHREADS*NTIMERS-1:0] fire,
    output logic                        exc_valid,
    output logic [THREAD_W-1:0]         exc_thread,
    output logic [TIMER_W-1:0]          exc_timer,
    output logic [NTHREADS*NTIMERS-1:0] grant
);
    localparam int NFLAT = NTHREADS * NTIMERS;

    int   sel;
    logic found;

    always_comb begin
        sel   = 0;
        found = 1'b0;
        for (int i = NFLAT - 1; i >= 0; i--) begin
            if (fire[i]) begin
                sel   = i;
                found = 1'b1;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NFLAT; i++) grant[i] = found && (sel == i);
    end

    assign exc_valid  = found;
    assign exc_thread = THREAD_W'(sel / NTIMERS);
    assign exc_timer  = TIMER_W'(sel % NTIMERS);

endmodule

// File: rtl/deadline_timer_unit.sv
module deadline_timer_unit #(
    parameter int NTHREADS = 4,
    parameter int NTIMERS  = 4,
    parameter int WIDTH    = 32,
    parameter int THREAD_W = (NTHREADS > 1) ? $clog2(NTHREADS) : 1,
    parameter int TIMER_W  = (NTIMERS > 1) ? $clog2(NTIMERS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue_valid,
    input  logic [THREAD_W-1:0]  issue_thread,
    input  logic [TIMER_W-1:0]   issue_timer,
    input  logic [1:0]           issue_op,
    input  logic [WIDTH-1:0]     issue_value,
    output logic [NTHREADS-1:0]  stall_vec,
    output logic                 exc_valid,
    output logic [THREAD_W-1:0]  exc_thread,
    output logic [TIMER_W-1:0]   exc_timer
);
    import dtu_pkg::*;

    localparam int NFLAT = NTHREADS * NTIMERS;

    logic [NFLAT-1:0] zero_flat;
    logic [NFLAT-1:0] armed_flat;
    logic [NFLAT-1:0] fire_flat;
    logic [NFLAT-1:0] grant_flat;
    op_e              op;

    assign op        = op_e'(issue_op);
    assign fire_flat = zero_flat & armed_flat;

    for (genvar t = 0; t < NTHREADS; t++) begin : g_thread
        logic               hit;
        logic               wr_en;
        logic [TIMER_W-1:0] wr_idx;
        logic [WIDTH-1:0]   wr_value;
        logic               wr_arm;

        assign hit = issue_valid && (issue_thread == THREAD_W'(t));

        dtu_thread_ctrl #(
            .NTIMERS (NTIMERS),
            .WIDTH   (WIDTH),
            .TIMER_W (TIMER_W)
        ) u_ctrl (
            .clk         (clk),
            .rst_n       (rst_n),
            .issue_hit   (hit),
            .issue_op    (op),
            .issue_idx   (issue_timer),
            .issue_value (issue_value),
            .zero_vec    (zero_flat[t*NTIMERS +: NTIMERS]),
            .wr_en       (wr_en),
            .wr_idx      (wr_idx),
            .wr_value    (wr_value),
            .wr_arm      (wr_arm),
            .stall       (stall_vec[t])
        );

        dtu_timer_bank #(
            .NTIMERS (NTIMERS),
            .WIDTH   (WIDTH),
            .TIMER_W (TIMER_W)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_en),
            .wr_idx    (wr_idx),
            .wr_value  (wr_value),
            .wr_arm    (wr_arm),
            .clr_arm   (grant_flat[t*NTIMERS +: NTIMERS]),
            .zero_vec  (zero_flat[t*NTIMERS +: NTIMERS]),
            .armed_vec (armed_flat[t*NTIMERS +: NTIMERS])
        );
    end

    dtu_exc_arbiter #(
        .NTHREADS (NTHREADS),
        .NTIMERS  (NTIMERS),
        .THREAD_W (THREAD_W),
        .TIMER_W  (TIMER_W)
    ) u_arb (
        .fire       (fire_flat),
        .exc_valid  (exc_valid),
        .exc_thread (exc_thread),
        .exc_timer  (exc_timer),
        .grant      (grant_flat)
    );

endmodule

// File: rtl/dtu_checker.sv
module dtu_checker #(
    parameter int NTHREADS = 4,
    parameter int NTIMERS  = 4,
    parameter int THREAD_W = 2,
    parameter int TIMER_W  = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        issue_valid,
    input logic [1:0]                  issue_op,
    input logic [NTHREADS-1:0]         stall_vec,
    input logic                        exc_valid,
    input logic [THREAD_W-1:0]         exc_thread,
    input logic [TIMER_W-1:0]          exc_timer,
    input logic [NTHREADS*NTIMERS-1:0] fire_flat
);
    localparam int NFLAT = NTHREADS * NTIMERS;

    int   exc_flat;
    logic lower_fire;
    logic own_fire;

    always_comb begin
        exc_flat   = int'(exc_thread) * NTIMERS + int'(exc_timer);
        lower_fire = 1'b0;
        own_fire   = 1'b0;
        for (int i = 0; i < NFLAT; i++) begin
            if (i < exc_flat && fire_flat[i]) lower_fire = 1'b1;
            if (i == exc_flat && fire_flat[i]) own_fire  = 1'b1;
        end
    end

    // R9
    exc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && !issue_valid) |=>
        !(exc_valid && exc_thread == $past(exc_thread) && exc_timer == $past(exc_timer)));

    // R9
    exc_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_flat != '0) |-> (exc_valid && own_fire));

    // R10
    exc_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> !lower_fire);

    // R5
    stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stall_vec & ~$past(stall_vec)) != '0) |->
        ($past(issue_valid) && ($past(issue_op) == 2'b01 || $past(issue_op) == 2'b10)));

    // R5
    stall_single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stall_vec & ~$past(stall_vec)));

endmodule

bind deadline_timer_unit dtu_checker #(
    .NTHREADS (NTHREADS),
    .NTIMERS  (NTIMERS),
    .THREAD_W (THREAD_W),
    .TIMER_W  (TIMER_W)
) u_dtu_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .issue_op    (issue_op),
    .stall_vec   (stall_vec),
    .exc_valid   (exc_valid),
    .exc_thread  (exc_thread),
    .exc_timer   (exc_timer),
    .fire_flat   (fire_flat)
);

// File: tb/test_deadline_timer_unit.sv
module test_deadline_timer_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [1:0]  issue_thread = '0;
    logic [1:0]  issue_timer = '0;
    logic [1:0]  issue_op = '0;
    logic [31:0] issue_value = '0;
    logic [3:0]  stall_vec;
    logic        exc_valid;
    logic [1:0]  exc_thread;
    logic [1:0]  exc_timer;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    deadline_timer_unit i_deadline_timer_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue_valid  (issue_valid),
        .issue_thread (issue_thread),
        .issue_timer  (issue_timer),
        .issue_op     (issue_op),
        .issue_value  (issue_value),
        .stall_vec    (stall_vec),
        .exc_valid    (exc_valid),
        .exc_thread   (exc_thread),
        .exc_timer    (exc_timer)
    );

    // vector: thread[11:10] timer[9:8] armed immediate-load value[7:0]
    localparam logic [11:0] VEC [6] = '{
        {2'd0, 2'd0, 8'd3},
        {2'd1, 2'd3, 8'd0},
        {2'd3, 2'd2, 8'd12},
        {2'd2, 2'd1, 8'd1},
        {2'd0, 2'd3, 8'd25},
        {2'd3, 2'd0, 8'd7}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the falling edge of the cycle after issue
    task automatic issue(input int thr, input int tim, input logic [1:0] op, input int val);
        issue_valid  = 1'b1;
        issue_thread = 2'(thr);
        issue_timer  = 2'(tim);
        issue_op     = op;
        issue_value  = 32'(val);
        @(negedge clk);
        issue_valid  = 1'b0;
    endtask

    task automatic observe(input int thr, input int cycles, output int stall_cnt,
                           output int first_n, output int first_thr,
                           output int first_tim, output int total);
        stall_cnt = 0; first_n = -1; first_thr = -1; first_tim = -1; total = 0;
        for (int i = 0; i < cycles; i++) begin
            if (stall_vec[thr]) stall_cnt++;
            if (exc_valid) begin
                if (total == 0) begin
                    first_n   = i;
                    first_thr = int'(exc_thread);
                    first_tim = int'(exc_timer);
                end
                total++;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int sc, fn, ft, fm, tot;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(stall_vec == 4'd0, "R1 stall after reset", int'(stall_vec), 0);
        chk(exc_valid == 1'b0, "R1 exc after reset", int'(exc_valid), 0);

        // R2 R3 R4 R9: armed immediate loads from the table
        for (int k = 0; k < 6; k++) begin
            int thr, tim, val;
            thr = int'(VEC[k][11:10]);
            tim = int'(VEC[k][9:8]);
            val = int'(VEC[k][7:0]);
            issue(thr, tim, 2'b11, val);
            observe(thr, val + 20, sc, fn, ft, fm, tot);
            chk(fn == val, "R3 exception cycle", fn, val);
            chk(ft == thr, "R9 exception thread", ft, thr);
            chk(fm == tim, "R9 exception timer", fm, tim);
            chk(tot == 1, "R4 single report", tot, 1);
        end

        // R5 R6: waiting armed load on a running timer (T=10, V=7)
        issue(2, 0, 2'b00, 10);
        issue(2, 0, 2'b10, 7);
        observe(2, 40, sc, fn, ft, fm, tot);
        chk(sc == 9, "R5 stall length", sc, 9);
        chk(fn == 17, "R6 exception after release", fn, 17);
        chk(ft == 2 && fm == 0, "R6 exception source", ft * 4 + fm, 8);
        chk(tot == 1, "R6 single report", tot, 1);

        // R7: waiting load on a zero timer acts at once
        issue(1, 1, 2'b10, 4);
        observe(1, 20, sc, fn, ft, fm, tot);
        chk(sc == 0, "R7 no stall", sc, 0);
        chk(fn == 4, "R7 immediate write", fn, 4);

        // R11: plain load on thread 0 leaves thread 1 arming intact
        issue(1, 0, 2'b11, 6);
        issue(0, 0, 2'b00, 50);
        observe(1, 20, sc, fn, ft, fm, tot);
        chk(fn == 5 && ft == 1 && fm == 0, "R11 other thread untouched", fn, 5);
        chk(tot == 1, "R11 single report", tot, 1);

        // R8: plain load clears arming
        issue(3, 3, 2'b11, 20);
        issue(3, 3, 2'b00, 2);
        observe(3, 40, sc, fn, ft, fm, tot);
        chk(tot == 0, "R8 arming cleared", tot, 0);

        // R12: operation from a stalled thread is ignored
        issue(2, 2, 2'b00, 15);
        issue(2, 2, 2'b01, 3);
        issue(2, 3, 2'b11, 0);
        observe(2, 40, sc, fn, ft, fm, tot);
        chk(tot == 0, "R12 ignored while stalled", tot, 0);
        chk(sc == 13, "R5 stall length while ignoring", sc, 13);

        // R10: simultaneous expiry, lowest flat index first
        issue(3, 1, 2'b11, 5);
        issue(1, 2, 2'b11, 4);
        observe(0, 20, sc, fn, ft, fm, tot);
        chk(fn == 4, "R10 first report cycle", fn, 4);
        chk(ft == 1 && fm == 2, "R10 priority winner", ft * 4 + fm, 6);
        chk(tot == 2, "R10 none lost", tot, 2);

        // R1: reset discards an armed deadline
        issue(0, 1, 2'b11, 6);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        observe(0, 20, sc, fn, ft, fm, tot);
        chk(tot == 0, "R1 reset disarms", tot, 0);
        chk(stall_vec == 4'd0, "R1 idle after reset", int'(stall_vec), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule